// File: doc/BRIEF.md
# Timestamp-Window Event Merger

The merger rebuilds complete detector events from four readout streams, each of which carries only part of every event. Every stream delivers fragments beat by beat into its own input FIFO. A fragment is one or more beats that share a timestamp, and the final beat is flagged. Each beat carries one hit: a 9-bit per-board channel number and a 2-bit source board number. Timestamps are 32-bit unsigned counts of 25 ns ticks.

Once enough complete fragments are buffered, the merger looks at the four FIFO heads. The earliest head timestamp becomes the base time of a new event. The merger then keeps absorbing whole fragments whose timestamp lies no more than WIN ticks above the base, from any stream and possibly several from the same stream, until no head qualifies. The gathered hits are sent as a 128-bit word stream: one header word, then data words of eight hit slots each.

Both edges use valid/ready. An input beat is taken on a cycle where `in_valid[s]` and `in_ready[s]` are both high, and `in_ready[s]` is low only while FIFO `s` is full. An output word is transferred on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. Input FIFOs keep filling during a stall until they are full.

Top module: `evt_merger`

## Requirements
- R1: No event starts until the number of complete fragments held across the four FIFOs reaches `start_level`. After that, events keep being built until every FIFO is empty, at which point the gate closes again.
- R2: The base time of an event is the smallest head timestamp among the non-empty FIFOs, and the header reports that base time.
- R3: A head fragment joins the current event only if its timestamp Tx satisfies Tb <= Tx <= Tb + WIN, with WIN = 1 tick by default. A fragment 2 ticks above the base starts a later event.
- R4: Selection repeats after every absorbed fragment, so a stream may contribute several fragments to one event. When several heads qualify, the lowest-numbered stream goes first, and hits keep their arrival order within a fragment.
- R5: Each hit's 11-bit ID is the board number in bits 10:9 above the 9-bit channel, and its slot also records the stream index (0 to 3) that supplied it. The stream index may differ from the board number.
- R6: Header word: bits 31:0 hold the base time, bits 47:32 hold the hit count, and all other bits are zero. Data slot k occupies bits 16k+15:16k and contains bit 15 = valid, bits 14:13 = stream, bits 12:11 = 0, bits 10:0 = ID. Unused slots are all zero, and `out_last` is high only on the final data word.
- R7: While `out_valid` is high and `out_ready` is low, the output word, its last flag and `out_valid` stay unchanged.
- R8: `in_ready[s]` goes low once FIFO s holds FIFO_DEPTH beats (16 by default), and no accepted beat is lost.
- R9: Empty FIFOs take no part in base selection or window checks. With all FIFOs empty, `out_valid` stays low.
- R10: At most MAX_HITS hits (64 by default) are stored per event. Further hits are consumed and dropped, and the header count reports the stored hits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_level | input | LVL_W | Buffered-fragment count that opens merging |
| in_valid | input | 4 | Beat valid, one bit per stream |
| in_ready | output | 4 | FIFO not full, one bit per stream |
| in_ts | input | 128 | Fragment timestamp, 32 bits per stream (stream s at 32s+31:32s) |
| in_board | input | 8 | Source board number, 2 bits per stream |
| in_chan | input | 36 | Per-board channel, 9 bits per stream |
| in_last | input | 4 | Final beat of a fragment, one bit per stream |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 128 | Header or data word |
| out_last | output | 1 | Final data word of an event |

## Verification
If the base register or window compare goes wrong, fragments are split or fused. This shows at the next header as a wrong timestamp or hit count, within a few cycles of the heads becoming visible. A faulty stream selector or hit buffer shows up in the first data word as a wrong stream field, a wrong ID or a broken order. A FIFO or gate that miscounts shows either as an event emitted before `start_level` is reached or as `in_ready` staying high past the depth. Stalled output words are compared cycle by cycle against the first stalled value.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int NSTR   = 4;
  localparam int SRC_W  = 2;
  localparam int CHAN_W = 9;
  localparam int BRD_W  = 2;
  localparam int ID_W   = BRD_W + CHAN_W;
  localparam int TS_W   = 32;
  localparam int SLOT_W = 16;
  localparam int SLOTS  = 8;
  localparam int WORD_W = SLOT_W * SLOTS;
  localparam int NCNT_W = 16;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [BRD_W-1:0]  brd;
    logic [CHAN_W-1:0] chan;
  } beat_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [ID_W-1:0]  id;
  } hit_t;

  typedef enum logic [2:0] {
    S_START, S_SCAN, S_DRAIN, S_HDR, S_DATA
  } mst_t;
endpackage

// File: rtl/ev_fifo.sv
module ev_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [W-1:0]                wr_data,
  input  logic                        wr_mark,
  input  logic                        rd_en,
  output logic [W-1:0]                rd_data,
  output logic                        rd_mark,
  output logic                        empty,
  output logic                        full,
  output logic [$clog2(DEPTH+1)-1:0]  mark_cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH-1);

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, mcnt;
  logic          push, pop;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign {rd_mark, rd_data} = mem[rp];
  assign mark_cnt = mcnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_mark, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      mcnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      cnt  <= cnt + CW'(push) - CW'(pop);
      mcnt <= mcnt + CW'(push && wr_mark) - CW'(pop && rd_mark);
    end
  end

  // R8: occupancy never exceeds the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R8: a write offered to a full FIFO with no read leaves it unchanged
  a_r8_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (cnt == $past(cnt)));
  // R1: fragment-end count is bounded by occupancy
  a_r1_marks_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= cnt);
endmodule

// File: rtl/ev_window.sv
module ev_window import evm_pkg::*; #(
  parameter int WIN = 1
) (
  input  logic [TS_W-1:0]  head_ts [NSTR],
  input  logic [NSTR-1:0]  head_ok,
  input  logic [TS_W-1:0]  tb,
  output logic [TS_W-1:0]  min_ts,
  output logic [NSTR-1:0]  hit_mask,
  output logic [SRC_W-1:0] pick,
  output logic             any_hit
);
  always_comb begin
    logic found;
    found  = 1'b0;
    min_ts = '1;
    for (int i = 0; i < NSTR; i++) begin
      if (head_ok[i] && (!found || head_ts[i] < min_ts)) begin
        min_ts = head_ts[i];
        found  = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSTR; g++) begin : g_win
    logic [TS_W-1:0] diff;
    assign diff        = head_ts[g] - tb;
    assign hit_mask[g] = head_ok[g] && (head_ts[g] >= tb) && (diff <= TS_W'(WIN));
  end

  always_comb begin
    pick = '0;
    for (int i = NSTR-1; i >= 0; i--) begin
      if (hit_mask[i]) pick = SRC_W'(i);
    end
  end

  assign any_hit = |hit_mask;
endmodule

// File: rtl/ev_frame.sv
module ev_frame import evm_pkg::*; #(
  parameter int MAX_HITS = 64
) (
  input  logic                         is_hdr,
  input  logic [TS_W-1:0]              tb,
  input  logic [$clog2(MAX_HITS+1)-1:0] cnt,
  input  logic [((MAX_HITS+SLOTS-1)/SLOTS > 1 ? $clog2((MAX_HITS+SLOTS-1)/SLOTS) : 1)-1:0] wi,
  input  hit_t                         hits [MAX_HITS],
  output logic [WORD_W-1:0]            word
);
  localparam int HA_W = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1;

  logic [WORD_W-1:0] hdr_w, dat_w;

  always_comb begin
    hdr_w = '0;
    hdr_w[TS_W-1:0]           = tb;
    hdr_w[TS_W+NCNT_W-1:TS_W] = NCNT_W'(cnt);
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [31:0] pos;
    hit_t        h;
    assign pos = 32'(wi) * 32'(SLOTS) + 32'(k);
    assign h   = hits[pos[HA_W-1:0]];
    assign dat_w[k*SLOT_W +: SLOT_W] = (pos < 32'(cnt)) ?
        {1'b1, h.src, 2'b00, h.id} : '0;
  end

  assign word = is_hdr ? hdr_w : dat_w;
endmodule

// File: rtl/ev_builder.sv
module ev_builder import evm_pkg::*; #(
  parameter int MAX_HITS = 64,
  parameter int WIN      = 1,
  parameter int LVL_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  start_level,
  input  logic [LVL_W-1:0]  frag_total,
  input  beat_t             head [NSTR],
  input  logic [NSTR-1:0]   head_last,
  input  logic [NSTR-1:0]   empty,
  output logic [NSTR-1:0]   pop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int HA_W   = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1;
  localparam int HC_W   = $clog2(MAX_HITS+1);
  localparam int NWORDS = (MAX_HITS + SLOTS - 1) / SLOTS;
  localparam int WI_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int EP_W   = HC_W + 4;

  mst_t             st;
  logic [TS_W-1:0]  tb;
  logic [SRC_W-1:0] sel;
  logic [HC_W-1:0]  cnt;
  logic [WI_W-1:0]  wi;
  logic             armed;
  hit_t             hitbuf [MAX_HITS];

  logic [TS_W-1:0]  head_ts [NSTR];
  logic [TS_W-1:0]  min_ts;
  logic [NSTR-1:0]  hit_mask;
  logic [SRC_W-1:0] pick;
  logic             any_hit, any_ne, begin_ev, take, lastw;
  logic [EP_W-1:0]  endpos;

  always_comb begin
    for (int i = 0; i < NSTR; i++) head_ts[i] = head[i].ts;
  end

  ev_window #(.WIN(WIN)) u_win (
    .head_ts (head_ts),
    .head_ok (~empty),
    .tb      (tb),
    .min_ts  (min_ts),
    .hit_mask(hit_mask),
    .pick    (pick),
    .any_hit (any_hit)
  );

  assign any_ne   = |(~empty);
  assign begin_ev = (st == S_START) && any_ne && (armed || frag_total >= start_level);
  assign take     = (st == S_DRAIN) && !empty[sel];

  always_comb begin
    pop = '0;
    if (take) pop[sel] = 1'b1;
  end

  assign endpos    = EP_W'(wi) * EP_W'(SLOTS) + EP_W'(SLOTS);
  assign lastw     = endpos >= EP_W'(cnt);
  assign out_valid = (st == S_HDR) || (st == S_DATA);
  assign out_last  = (st == S_DATA) && lastw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_START;
      tb    <= '0;
      sel   <= '0;
      cnt   <= '0;
      wi    <= '0;
      armed <= 1'b0;
    end else begin
      case (st)
        S_START: begin
          if (begin_ev) begin
            tb    <= min_ts;
            cnt   <= '0;
            armed <= 1'b1;
            st    <= S_SCAN;
          end else if (!any_ne) begin
            armed <= 1'b0;
          end
        end
        S_SCAN: begin
          if (any_hit) begin
            sel <= pick;
            st  <= S_DRAIN;
          end else begin
            st  <= S_HDR;
          end
        end
        S_DRAIN: begin
          if (take) begin
            if (cnt < HC_W'(MAX_HITS)) cnt <= cnt + 1'b1;
            if (head_last[sel]) st <= S_SCAN;
          end
        end
        S_HDR: begin
          if (out_ready) begin
            wi <= '0;
            st <= S_DATA;
          end
        end
        S_DATA: begin
          if (out_ready) begin
            if (lastw) st <= S_START;
            else       wi <= wi + 1'b1;
          end
        end
        default: st <= S_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take && cnt < HC_W'(MAX_HITS))
      hitbuf[cnt[HA_W-1:0]] <= '{src: sel, id: {head[sel].brd, head[sel].chan}};
  end

  ev_frame #(.MAX_HITS(MAX_HITS)) u_frame (
    .is_hdr(st == S_HDR),
    .tb    (tb),
    .cnt   (cnt),
    .wi    (wi),
    .hits  (hitbuf),
    .word  (out_data)
  );

  // R7: stalled output word is held
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R6: a transferred last word is followed by an idle cycle before a new header
  a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
  // R10: stored hit count never exceeds capacity
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HC_W'(MAX_HITS));
  // R1: an event only appears while the merge gate is open
  a_r1_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> armed);
  // R9: a pop never targets an empty FIFO
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (|pop) |-> (|(pop & ~empty)));
endmodule

// File: rtl/evt_merger.sv
module evt_merger import evm_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_HITS   = 64,
  parameter int WIN        = 1,
  parameter int LVL_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LVL_W-1:0]       start_level,
  input  logic [NSTR-1:0]        in_valid,
  output logic [NSTR-1:0]        in_ready,
  input  logic [NSTR*TS_W-1:0]   in_ts,
  input  logic [NSTR*BRD_W-1:0]  in_board,
  input  logic [NSTR*CHAN_W-1:0] in_chan,
  input  logic [NSTR-1:0]        in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_last
);
  localparam int MC_W = $clog2(FIFO_DEPTH+1);
  localparam int BW   = $bits(beat_t);

  beat_t            head [NSTR];
  logic [NSTR-1:0]  head_last, empty, full, pop;
  logic [MC_W-1:0]  mcnt [NSTR];
  logic [LVL_W-1:0] frag_total;

  for (genvar g = 0; g < NSTR; g++) begin : g_lane
    logic [BW-1:0] raw;
    ev_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid[g]),
      .wr_data ({in_ts[g*TS_W +: TS_W], in_board[g*BRD_W +: BRD_W], in_chan[g*CHAN_W +: CHAN_W]}),
      .wr_mark (in_last[g]),
      .rd_en   (pop[g]),
      .rd_data (raw),
      .rd_mark (head_last[g]),
      .empty   (empty[g]),
      .full    (full[g]),
      .mark_cnt(mcnt[g])
    );
    assign head[g]     = beat_t'(raw);
    assign in_ready[g] = !full[g];
  end

  always_comb begin
    frag_total = '0;
    for (int i = 0; i < NSTR; i++) frag_total = frag_total + LVL_W'(mcnt[i]);
  end

  ev_builder #(.MAX_HITS(MAX_HITS), .WIN(WIN), .LVL_W(LVL_W)) u_build (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_level(start_level),
    .frag_total (frag_total),
    .head       (head),
    .head_last  (head_last),
    .empty      (empty),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
  );
endmodule

// File: tb/evt_merger_tb.sv
`timescale 1ns/1ps
module evt_merger_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   start_level = 8'd1;
  logic [3:0]   in_valid = '0;
  logic [3:0]   in_ready;
  logic [127:0] in_ts = '0;
  logic [7:0]   in_board = '0;
  logic [35:0]  in_chan = '0;
  logic [3:0]   in_last = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [127:0] cap_d [256];
  logic         cap_l [256];
  int           ncap = 0;

  always #2.5 clk = ~clk;

  evt_merger dut_i (
    .clk(clk), .rst_n(rst_n), .start_level(start_level),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts),
    .in_board(in_board), .in_chan(in_chan), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 256) begin
      cap_d[ncap] = out_data;
      cap_l[ncap] = out_last;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] slot(input int src, input int brd, input int chan);
    return {1'b1, 2'(src), 2'b00, 2'(brd), 9'(chan)};
  endfunction

  function automatic logic [127:0] hdr(input int ts, input int n);
    return {80'd0, 16'(n), 32'(ts)};
  endfunction

  task automatic chk_word(input int i, input logic [127:0] exp, input bit lst, input string req);
    chk(i < ncap && cap_d[i] == exp, req, (i < ncap) ? cap_d[i] : 'x, exp);
    chk(i < ncap && cap_l[i] == lst, {req, " last"}, (i < ncap) ? 128'(cap_l[i]) : 'x, 128'(lst));
  endtask

  task automatic push_beat(input int s, input int ts, input int brd, input int chan, input bit lst);
    in_ts[s*32 +: 32] = 32'(ts);
    in_board[s*2 +: 2] = 2'(brd);
    in_chan[s*9 +: 9] = 9'(chan);
    in_last[s] = lst;
    in_valid[s] = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready[s]) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    in_valid[s] = 1'b0;
    in_last[s] = 1'b0;
  endtask

  task automatic push_frag(input int s, input int ts, input int brd, input int c0, input int n);
    for (int i = 0; i < n; i++) push_beat(s, ts, brd, c0 + i, i == n - 1);
  endtask

  task automatic wait_caps(input int n);
    for (int i = 0; i < 3000 && ncap < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", 128'(out_valid), 0);
    chk(in_ready == 4'hF, "R8 reset in_ready", 128'(in_ready), 128'hF);
  endtask

  task automatic t_window;
    ncap = 0;
    start_level = 8'd3;
    push_frag(2, 100, 2, 5, 2);
    push_frag(0, 101, 0, 7, 1);
    repeat (30) @(negedge clk);
    chk(ncap == 0 && !out_valid, "R1 gate closed below level", 128'(ncap), 0);
    @(posedge clk); #1;
    push_frag(1, 103, 1, 9, 1);
    wait_caps(4);
    chk(ncap == 4, "R3 two events", 128'(ncap), 4);
    chk_word(0, hdr(100, 3), 0, "R2 base header");
    chk_word(1, {80'd0, slot(2, 2, 6), slot(2, 2, 5), slot(0, 0, 7)}, 1, "R4 order R6 slots");
    chk_word(2, hdr(103, 1), 0, "R3 outside window separate");
    chk_word(3, {112'd0, slot(1, 1, 9)}, 1, "R6 single slot");
  endtask

  task automatic t_repeat;
    ncap = 0;
    start_level = 8'd4;
    push_frag(0, 200, 0, 1, 1);
    push_frag(0, 201, 0, 2, 1);
    push_frag(3, 201, 3, 3, 1);
    push_frag(1, 202, 1, 4, 1);
    wait_caps(4);
    chk(ncap == 4, "R4 beat count", 128'(ncap), 4);
    chk_word(0, hdr(200, 3), 0, "R4 same-stream repeat");
    chk_word(1, {80'd0, slot(3, 3, 3), slot(0, 0, 2), slot(0, 0, 1)}, 1, "R4 gather order");
    chk_word(2, hdr(202, 1), 0, "R3 two ticks above base");
  endtask

  task automatic t_id;
    ncap = 0;
    start_level = 8'd1;
    push_frag(1, 400, 3, 511, 1);
    wait_caps(2);
    chk_word(0, hdr(400, 1), 0, "R5 header");
    chk_word(1, {112'd0, 16'hA7FF}, 1, "R5 id 2047 stream 1");
  endtask

  task automatic t_backpressure;
    logic [127:0] held;
    int waited;
    ncap = 0;
    start_level = 8'd1;
    out_ready = 1'b0;
    push_frag(0, 300, 0, 20, 10);
    waited = 0;
    while (!out_valid && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    held = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == held, "R7 stall hold", out_data, held);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    wait_caps(3);
    chk_word(0, hdr(300, 10), 0, "R7 header after stall");
    chk_word(1, {slot(0, 0, 27), slot(0, 0, 26), slot(0, 0, 25), slot(0, 0, 24),
                 slot(0, 0, 23), slot(0, 0, 22), slot(0, 0, 21), slot(0, 0, 20)}, 0, "R6 full word");
    chk_word(2, {96'd0, slot(0, 0, 29), slot(0, 0, 28)}, 1, "R6 unused slots zero");
  endtask

  task automatic t_full;
    ncap = 0;
    start_level = 8'd100;
    for (int k = 0; k < 16; k++) push_frag(2, 600 + 10 * k, 2, k, 1);
    @(negedge clk);
    chk(in_ready[2] == 1'b0, "R8 full deasserts ready", 128'(in_ready[2]), 0);
    chk(in_ready[0] == 1'b1, "R8 other lane ready", 128'(in_ready[0]), 1);
    @(posedge clk); #1;
    start_level = 8'd1;
    wait_caps(32);
    chk(ncap == 32, "R8 all beats kept", 128'(ncap), 32);
    for (int k = 0; k < 16; k++) begin
      chk_word(2 * k, hdr(600 + 10 * k, 1), 0, "R8 header");
      chk_word(2 * k + 1, {112'd0, slot(2, 2, k)}, 1, "R8 data");
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!out_valid, "R9 idle when empty", 128'(out_valid), 0);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_overflow;
    ncap = 0;
    start_level = 8'd1;
    fork
      push_frag(0, 5000, 0, 0, 70);
      push_frag(1, 4990, 1, 3, 1);
    join
    wait_caps(11);
    chk(ncap == 11, "R10 beat count", 128'(ncap), 11);
    chk_word(0, hdr(4990, 1), 0, "R2 earliest first");
    chk_word(1, {112'd0, slot(1, 1, 3)}, 1, "R9 data");
    chk_word(2, hdr(5000, 64), 0, "R10 capped count");
    for (int w = 0; w < 8; w++) begin
      logic [127:0] e;
      for (int k = 0; k < 8; k++) e[k*16 +: 16] = slot(0, 0, 8 * w + k);
      chk_word(3 + w, e, w == 7, "R10 data");
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    t_window();
    t_repeat();
    t_id();
    t_backpressure();
    t_full();
    t_overflow();
    finish_run();
  end
endmodule